// File: doc/BRIEF.md
# Thermal Sensor Bus Tick Generator

This block supplies the timing strobes for a single-wire thermal sensor bus controller. A programmable baud divisor sets the length of a quarter of a bus bit. The block emits a one-cycle strobe at each quarter-bit boundary and a second strobe at every fourth one, which marks the end of a full bit. A bit therefore lasts four times the baud divisor in input clocks.

A second timer asks the controller to begin a new round of temperature reads. The input clock first passes through a fixed divide-by-4096 prescaler. A poll divisor then sets how many prescaled intervals pass between poll requests. A poll divisor of zero turns polling off. The controller sets both divisors and an enable. Values below the legal floor are raised to the floor. A divisor changed during a run is picked up only at the next terminal count, so no running interval is cut short.

Top module: `thermbus_tick_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls with `run_en` low, `qtr_tick`, `bit_tick` and `poll_req` are all 0.
- R2: With `run_en` high, `qtr_tick` pulses once every D input clock cycles, where D is the effective baud divisor. The first pulse comes D cycles after the first rising clock edge at which `run_en` is sampled high.
- R3: `qtr_tick` and `bit_tick` are each high for one cycle only. `bit_tick` is high only together with `qtr_tick`, on every fourth quarter tick counted from enable, so bit ticks are 4*D cycles apart.
- R4: A `baud_div` value below 8, including 0, acts as 8.
- R5: The largest `baud_div` value, 65535, is used as given and yields a quarter period of 65535 cycles.
- R6: A new `baud_div` written while running takes effect only after the current quarter period ends. The period in progress keeps its old length.
- R7: While `run_en` is low, no tick or poll request is issued and all counters are held at zero. After re-enable, the next tick comes a full period after the enabling edge.
- R8: With a nonzero poll divisor N, `poll_req` pulses every 4096*N cycles. The first pulse comes 4096*N cycles after enable.
- R9: `poll_req` is high for one cycle only. After each pulse the poll count restarts from zero, so pulses repeat at the same spacing.
- R10: With `poll_div` equal to 0, `poll_req` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Enables both timers; low clears all counters |
| baud_div | input | 16 | Programmed quarter-bit divisor in clocks, raised to at least 8 |
| poll_div | input | 16 | Poll interval in units of 4096 clocks; 0 disables polling |
| qtr_tick | output | 1 | One-cycle strobe at every quarter-bit boundary |
| bit_tick | output | 1 | One-cycle strobe at every fourth quarter tick |
| poll_req | output | 1 | One-cycle strobe requesting a new poll round |

## Verification
The assertions assume that `rst` is held high for at least one clock before checking starts. They also assume that divisor inputs change only between clock edges and never take unknown values. The minimum-gap check counts only gaps that lie wholly inside one enabled stretch, because disabling the block restarts the quarter count. The bench changes `baud_div`, `poll_div` and `run_en` only at falling edges and keeps every value inside the 16-bit port range. It also holds `poll_div` at zero for the entire enabled stretch in which poll suppression is checked.

// File: rtl/tick_gen_pkg.sv
package tick_gen_pkg;

  // Limit a requested divisor to the legal window [lo, hi].
  function automatic int unsigned limit_div(input int unsigned raw,
                                            input int unsigned lo,
                                            input int unsigned hi);
    int unsigned v;
    v = raw;
    if (v < lo) v = lo;
    if (v > hi) v = hi;
    return v;
  endfunction

endpackage

// File: rtl/div_limit.sv
module div_limit #(
  parameter int DIV_W   = 16,
  parameter int MIN_DIV = 8,
  parameter int MAX_DIV = 65535
) (
  input  logic [DIV_W-1:0] raw_div,
  output logic [DIV_W-1:0] eff_div
);
  import tick_gen_pkg::*;

  always_comb begin
    eff_div = DIV_W'(limit_div(32'(raw_div), MIN_DIV, MAX_DIV));
  end
endmodule

// File: rtl/quarter_timer.sv
module quarter_timer #(
  parameter int DIV_W   = 16,
  parameter int MIN_DIV = 8,
  parameter int QPB     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic [DIV_W-1:0] eff_div,
  output logic             qtr_tick,
  output logic             bit_tick
);
  localparam int QW = (QPB > 1) ? $clog2(QPB) : 1;
  localparam logic [QW-1:0] LAST_Q = QW'(QPB - 1);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_live;
  logic [QW-1:0]    qidx;
  logic             at_end;

  assign at_end = (cnt == div_live - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      div_live <= DIV_W'(MIN_DIV);
      qidx     <= '0;
      qtr_tick <= 1'b0;
      bit_tick <= 1'b0;
    end else if (!run_en) begin
      cnt      <= '0;
      div_live <= eff_div;
      qidx     <= '0;
      qtr_tick <= 1'b0;
      bit_tick <= 1'b0;
    end else if (at_end) begin
      cnt      <= '0;
      div_live <= eff_div;
      qtr_tick <= 1'b1;
      bit_tick <= (qidx == LAST_Q);
      qidx     <= (qidx == LAST_Q) ? '0 : qidx + QW'(1);
    end else begin
      cnt      <= cnt + DIV_W'(1);
      qtr_tick <= 1'b0;
      bit_tick <= 1'b0;
    end
  end
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int POLL_W   = 16,
  parameter int PRESCALE = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic [POLL_W-1:0] poll_div,
  output logic              poll_req
);
  localparam int PW = $clog2(PRESCALE);
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

  logic [PW-1:0]     pre_cnt;
  logic [POLL_W-1:0] slow_cnt;
  logic [POLL_W-1:0] poll_live;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt   <= '0;
      slow_cnt  <= '0;
      poll_live <= '0;
      poll_req  <= 1'b0;
    end else if (!run_en || poll_live == '0) begin
      // Idle: hold the counters and follow the programmed divisor.
      pre_cnt   <= '0;
      slow_cnt  <= '0;
      poll_live <= poll_div;
      poll_req  <= 1'b0;
    end else if (pre_cnt == PRE_LAST) begin
      pre_cnt <= '0;
      if (slow_cnt == poll_live - POLL_W'(1)) begin
        slow_cnt  <= '0;
        poll_live <= poll_div;
        poll_req  <= 1'b1;
      end else begin
        slow_cnt <= slow_cnt + POLL_W'(1);
        poll_req <= 1'b0;
      end
    end else begin
      pre_cnt  <= pre_cnt + PW'(1);
      poll_req <= 1'b0;
    end
  end
endmodule

// File: rtl/thermbus_tick_gen.sv
module thermbus_tick_gen #(
  parameter int DIV_W    = 16,
  parameter int MIN_DIV  = 8,
  parameter int MAX_DIV  = 65535,
  parameter int QPB      = 4,
  parameter int POLL_W   = 16,
  parameter int PRESCALE = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic [POLL_W-1:0] poll_div,
  output logic              qtr_tick,
  output logic              bit_tick,
  output logic              poll_req
);
  logic [DIV_W-1:0] eff_div;

  div_limit #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV)) u_limit (
    .raw_div (baud_div),
    .eff_div (eff_div)
  );

  quarter_timer #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV), .QPB(QPB)) u_qtr (
    .clk      (clk),
    .rst      (rst),
    .run_en   (run_en),
    .eff_div  (eff_div),
    .qtr_tick (qtr_tick),
    .bit_tick (bit_tick)
  );

  poll_timer #(.POLL_W(POLL_W), .PRESCALE(PRESCALE)) u_poll (
    .clk      (clk),
    .rst      (rst),
    .run_en   (run_en),
    .poll_div (poll_div),
    .poll_req (poll_req)
  );
endmodule

// File: rtl/tick_gen_checker.sv
module tick_gen_checker #(
  parameter int DIV_W   = 16,
  parameter int MIN_DIV = 8,
  parameter int POLL_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              run_en,
  input logic [POLL_W-1:0] poll_div,
  input logic              qtr_tick,
  input logic              bit_tick,
  input logic              poll_req
);
  logic [DIV_W:0] gap;
  logic           seen_tick;
  logic           zero_poll_run;

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      gap       <= '0;
      seen_tick <= 1'b0;
    end else if (qtr_tick) begin
      gap       <= '0;
      seen_tick <= 1'b1;
    end else if (gap != {(DIV_W+1){1'b1}}) begin
      gap <= gap + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run_en) zero_poll_run <= (poll_div == '0);
    else                zero_poll_run <= zero_poll_run && (poll_div == '0);
  end

  // R3: bit strobe only together with a quarter strobe
  a_r3_bit_with_qtr: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> qtr_tick);

  // R3: quarter strobe lasts a single cycle
  a_r3_qtr_single: assert property (@(posedge clk) disable iff (rst)
    qtr_tick |=> !qtr_tick);

  // R4: quarter strobes never closer than the divisor floor
  a_r4_min_gap: assert property (@(posedge clk) disable iff (rst)
    (qtr_tick && seen_tick && run_en) |-> (gap >= (DIV_W+1)'(MIN_DIV - 1)));

  // R7: nothing issued after a disabled edge
  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (!qtr_tick && !bit_tick && !poll_req));

  // R9: poll request lasts a single cycle
  a_r9_poll_single: assert property (@(posedge clk) disable iff (rst)
    poll_req |=> !poll_req);

  // R10: zero poll divisor throughout a run keeps requests off
  a_r10_zero_poll: assert property (@(posedge clk) disable iff (rst)
    zero_poll_run |-> !poll_req);
endmodule

bind thermbus_tick_gen tick_gen_checker #(
  .DIV_W(DIV_W), .MIN_DIV(MIN_DIV), .POLL_W(POLL_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .run_en   (run_en),
  .poll_div (poll_div),
  .qtr_tick (qtr_tick),
  .bit_tick (bit_tick),
  .poll_req (poll_req)
);

// File: tb/thermbus_tick_gen_test.sv
module thermbus_tick_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0;
  logic [15:0] baud_div = 16'd10;
  logic [15:0] poll_div = 16'd0;
  logic        qtr_tick, bit_tick, poll_req;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  thermbus_tick_gen uut (
    .clk(clk), .rst(rst), .run_en(run_en), .baud_div(baud_div),
    .poll_div(poll_div), .qtr_tick(qtr_tick), .bit_tick(bit_tick),
    .poll_req(poll_req)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_qtr(output int at);
    do @(negedge clk); while (!qtr_tick);
    at = cyc;
  endtask

  task automatic wait_bit(output int at);
    do @(negedge clk); while (!bit_tick);
    at = cyc;
  endtask

  task automatic wait_poll(output int at);
    do @(negedge clk); while (!poll_req);
    at = cyc;
  endtask

  task automatic start_run(input int bd, input int pd, output int at);
    @(negedge clk);
    run_en = 1'b0;
    baud_div = 16'(bd);
    poll_div = 16'(pd);
    @(negedge clk);
    run_en = 1'b1;
    at = cyc;
  endtask

  task automatic stop_run();
    @(negedge clk);
    run_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 qtr_tick in reset", qtr_tick, 0);
    check("R1 bit_tick in reset", bit_tick, 0);
    check("R1 poll_req in reset", poll_req, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 outputs after reset", {qtr_tick, bit_tick, poll_req}, 0);
  endtask

  task automatic t_quarter_and_bit();
    int t0, t1, t2, b1, b2;
    start_run(10, 0, t0);
    wait_qtr(t1);
    check("R2 first quarter latency", t1 - t0, 10);
    @(negedge clk);
    check("R3 quarter single cycle", qtr_tick, 0);
    wait_qtr(t2);
    check("R2 quarter period", t2 - t1, 10);
    wait_bit(b1);
    check("R3 first bit latency", b1 - t0, 40);
    check("R3 bit with quarter", qtr_tick, 1);
    wait_bit(b2);
    check("R3 bit period", b2 - b1, 40);
    stop_run();
  endtask

  task automatic t_clamp();
    int t0, t1, t2;
    start_run(3, 0, t0);
    wait_qtr(t1);
    check("R4 clamp 3 latency", t1 - t0, 8);
    wait_qtr(t2);
    check("R4 clamp 3 period", t2 - t1, 8);
    stop_run();
    start_run(0, 0, t0);
    wait_qtr(t1);
    check("R4 clamp 0 latency", t1 - t0, 8);
    stop_run();
    start_run(8, 0, t0);
    wait_qtr(t1);
    check("R4 floor 8 latency", t1 - t0, 8);
    stop_run();
  endtask

  task automatic t_max();
    int t0, t1;
    start_run(65535, 0, t0);
    wait_qtr(t1);
    check("R5 max divisor latency", t1 - t0, 65535);
    stop_run();
  endtask

  task automatic t_change();
    int t0, t1, t2, t3;
    start_run(20, 0, t0);
    wait_qtr(t1);
    repeat (5) @(negedge clk);
    baud_div = 16'd12;
    wait_qtr(t2);
    check("R6 period in progress kept", t2 - t1, 20);
    wait_qtr(t3);
    check("R6 new divisor after terminal", t3 - t2, 12);
    stop_run();
  endtask

  task automatic t_disable();
    int t0, t1, n;
    start_run(16, 1, t0);
    repeat (7) @(negedge clk);
    run_en = 1'b0;
    @(negedge clk);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (qtr_tick || bit_tick || poll_req) n++;
    end
    check("R7 no strobes while disabled", n, 0);
    run_en = 1'b1;
    t0 = cyc;
    wait_qtr(t1);
    check("R7 full period after re-enable", t1 - t0, 16);
    stop_run();
  endtask

  task automatic t_poll();
    int t0, p1, p2;
    start_run(10, 1, t0);
    wait_poll(p1);
    check("R8 poll latency N=1", p1 - t0, 4096);
    @(negedge clk);
    check("R9 poll single cycle", poll_req, 0);
    wait_poll(p2);
    check("R9 poll repeats N=1", p2 - p1, 4096);
    stop_run();
    start_run(10, 2, t0);
    wait_poll(p1);
    check("R8 poll latency N=2", p1 - t0, 8192);
    wait_poll(p2);
    check("R9 poll repeats N=2", p2 - p1, 8192);
    stop_run();
  endtask

  task automatic t_poll_off();
    int t0, n;
    start_run(10, 0, t0);
    n = 0;
    for (int i = 0; i < 9000; i++) begin
      @(negedge clk);
      if (poll_req) n++;
    end
    check("R10 zero divisor no poll", n, 0);
    stop_run();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_quarter_and_bit();
    t_clamp();
    t_change();
    t_disable();
    t_poll();
    t_poll_off();
    t_max();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule